// File: doc/BRIEF.md
# Byte Store Sequencer for a Word-Only Memory

This block performs stores on a memory that can only move whole 16-bit words and has no byte-lane enables. Every store request fetches the destination word first, builds the new word, and then writes the whole word back. For a byte store, the new word is the fetched word with one byte replaced. For a word store, or for a clear or set-to-ones operation, the fetched value is discarded, but the fetch still takes place.

A requester presents a byte address, a byte/word flag, an operation code and data while `req_valid` is high. The request is taken on a clock edge at which `req_ready` is high. The sequencer then steps through five states: IDLE, READ, MERGE, WRITE and DONE. It issues exactly one memory read and one memory write, and pulses `req_done` for one cycle. The memory port assumes a synchronous read with one cycle of latency.

Top module: `rbw_store_seq`

## Requirements
- R1: `mem_addr` always equals the request's byte address with bit 0 dropped (address bits AW-1..1). Both bytes of a pair therefore reach the same word.
- R2: Every accepted request, of any size or operation, makes exactly one read and then exactly one write. The read is high in the first cycle after acceptance and the write is high in the third cycle.
- R3: A byte store to an even address places the new byte in bits 15..8 and keeps bits 7..0 of the fetched word. Example: writing FF to a word holding 0102 gives FF02.
- R4: A byte store to an odd address places the new byte in bits 7..0 and keeps bits 15..8 of the fetched word.
- R5: A word store (`req_byte`=0) writes all 16 bits of `req_data` and ignores the fetched value. The fetch is still performed.
- R6: `req_op` selects the value written: 2'b01 clears to zero and 2'b10 sets to all ones, within the addressed byte or across the whole word. Codes 2'b00 and 2'b11 store `req_data`, whose low 8 bits are the byte value. The operand is fetched for every code.
- R7: `req_done` is high for exactly one cycle, the cycle after the write cycle (the fourth cycle after acceptance).
- R8: `req_ready` is high only when idle. A request presented while busy is ignored and causes no memory access of its own.
- R9: After reset, `req_ready` is 1 and `mem_rd`, `mem_wr` and `req_done` are 0. `mem_rd` and `mem_wr` are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Sequencer idle, request will be taken |
| req_addr | input | AW | Byte address |
| req_byte | input | 1 | 1 = byte store, 0 = word store |
| req_op | input | 2 | 00/11 store data, 01 clear, 10 set to ones |
| req_data | input | 16 | Store data (low 8 bits for byte stores) |
| req_done | output | 1 | One-cycle completion pulse |
| mem_addr | output | AW-1 | Word address |
| mem_rd | output | 1 | Word read strobe |
| mem_wr | output | 1 | Word write strobe |
| mem_wdata | output | 16 | Write data |
| mem_rdata | input | 16 | Read data, valid the cycle after `mem_rd` |

## Verification
Counting from the accepting edge, the read strobe is due one cycle later, the read data is merged in the second cycle, the write strobe is due in the third, the done pulse in the fourth, and `req_ready` returns in the fifth. Each scenario task samples at falling edges and records the cycle index at which each strobe appears. It then compares that index with these expected positions and confirms that no second read or write follows within eight cycles. Stored word values are checked in the bench's own memory model after the done pulse.

// File: rtl/rbw_store_seq.sv
module rbw_store_seq #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  output logic          req_ready,
  input  logic [AW-1:0] req_addr,
  input  logic          req_byte,
  input  logic [1:0]    req_op,
  input  logic [15:0]   req_data,
  output logic          req_done,
  output logic [AW-2:0] mem_addr,
  output logic          mem_rd,
  output logic          mem_wr,
  output logic [15:0]   mem_wdata,
  input  logic [15:0]   mem_rdata
);
  localparam logic [1:0] OP_CLR = 2'b01;
  localparam logic [1:0] OP_SET = 2'b10;

  typedef enum logic [2:0] {S_IDLE, S_READ, S_MERGE, S_WRITE, S_DONE} st_t;

  st_t          st;
  logic [AW-2:0] wadr;
  logic          bsel, odd;
  logic [1:0]    op_q;
  logic [15:0]   dat_q, merged, src, next_word;

  assign req_ready = (st == S_IDLE);
  assign mem_rd    = (st == S_READ);
  assign mem_wr    = (st == S_WRITE);
  assign req_done  = (st == S_DONE);
  assign mem_addr  = wadr;
  assign mem_wdata = merged;

  assign src = (op_q == OP_CLR) ? 16'h0000 :
               (op_q == OP_SET) ? 16'hFFFF : dat_q;

  assign next_word = !bsel ? src :
                     odd   ? {mem_rdata[15:8], src[7:0]} :
                             {src[7:0], mem_rdata[7:0]};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      wadr   <= '0;
      bsel   <= 1'b0;
      odd    <= 1'b0;
      op_q   <= 2'b00;
      dat_q  <= '0;
      merged <= '0;
    end else begin
      case (st)
        S_IDLE: if (req_valid) begin
          wadr  <= req_addr[AW-1:1];
          odd   <= req_addr[0];
          bsel  <= req_byte;
          op_q  <= req_op;
          dat_q <= req_data;
          st    <= S_READ;
        end
        S_READ:  st <= S_MERGE;
        S_MERGE: begin
          merged <= next_word;
          st     <= S_WRITE;
        end
        S_WRITE: st <= S_DONE;
        default: st <= S_IDLE;
      endcase
    end
  end

  a_r9_rd_wr_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));

  a_r2_read_precedes_write: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> $past(mem_rd, 2));

  a_r1_same_word: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr == $past(mem_addr, 2));

  a_r3_even_keeps_low: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && bsel && !odd) |-> mem_wdata[7:0] == $past(mem_rdata[7:0]));

  a_r4_odd_keeps_high: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_wr && bsel && odd) |-> mem_wdata[15:8] == $past(mem_rdata[15:8]));

  a_r7_done_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |-> $past(mem_wr));

  a_r7_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    req_done |=> !req_done);

  a_r8_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
    mem_rd |=> !req_ready);
endmodule

// File: tb/sim_rbw_store_seq.sv
`timescale 1ns/1ps
module sim_rbw_store_seq;
  localparam int AW = 16;

  logic clk = 0, rst_n = 0;
  logic req_valid = 0, req_byte = 0;
  logic [AW-1:0] req_addr = '0;
  logic [1:0] req_op = 2'b00;
  logic [15:0] req_data = '0;
  logic req_ready, req_done, mem_rd, mem_wr;
  logic [AW-2:0] mem_addr;
  logic [15:0] mem_wdata, mem_rdata;

  logic [15:0] mem [16];
  int vectors = 0, miscompares = 0;
  bit finished = 0;

  always #2.5 clk = ~clk;

  rbw_store_seq #(.AW(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_byte(req_byte), .req_op(req_op), .req_data(req_data),
    .req_done(req_done), .mem_addr(mem_addr), .mem_rd(mem_rd), .mem_wr(mem_wr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  always @(posedge clk) begin
    if (mem_rd) mem_rdata <= mem[mem_addr[3:0]];
    if (mem_wr) mem[mem_addr[3:0]] <= mem_wdata;
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic issue(input [15:0] a, input logic b, input [1:0] op, input [15:0] d,
                       input bit hold_busy, input [15:0] busy_a);
    int rd_c = -1, wr_c = -1, dn_c = -1, nrd = 0, nwr = 0, ndn = 0;
    bit rdy_bad = 0, both = 0;
    logic [AW-2:0] ra = '0, wa = '0;
    @(negedge clk);
    req_valid = 1; req_addr = a; req_byte = b; req_op = op; req_data = d;
    for (int c = 1; c <= 8; c++) begin
      @(negedge clk);
      if (mem_rd) begin nrd++; rd_c = c; ra = mem_addr; end
      if (mem_wr) begin nwr++; wr_c = c; wa = mem_addr; end
      if (req_done) begin ndn++; dn_c = c; end
      if (mem_rd && mem_wr) both = 1;
      if (c <= 4 && req_ready) rdy_bad = 1;
      if (c == 5 && !req_ready) rdy_bad = 1;
      if (c == 1) begin
        if (hold_busy) begin req_addr = busy_a; req_data = 16'h5A5A; req_byte = 1; end
        else req_valid = 0;
      end
      if (c == 4) req_valid = 0;
    end
    chk(nrd == 1 && rd_c == 1, "R2 read count/cycle", rd_c, 1);
    chk(nwr == 1 && wr_c == 3, "R2 write count/cycle", wr_c, 3);
    chk(ra == a[AW-1:1] && wa == a[AW-1:1], "R1 word address", int'(wa), int'(a[AW-1:1]));
    chk(ndn == 1 && dn_c == 4, "R7 done pulse cycle", dn_c, 4);
    chk(!rdy_bad, "R8 ready only when idle", rdy_bad, 0);
    chk(!both, "R9 read/write exclusive", both, 0);
  endtask

  task automatic t_reset;
    chk(req_ready && !mem_rd && !mem_wr && !req_done, "R9 reset state",
        {req_ready, mem_rd, mem_wr, req_done}, 4'b1000);
  endtask

  task automatic t_byte_even;
    mem[0] = 16'h0102;
    issue(16'h0000, 1, 2'b00, 16'h00FF, 0, 0);
    chk(mem[0] == 16'hFF02, "R3 even byte merge", mem[0], 16'hFF02);
  endtask

  task automatic t_byte_odd;
    mem[1] = 16'h0102;
    issue(16'h0003, 1, 2'b11, 16'h77AB, 0, 0);
    chk(mem[1] == 16'h01AB, "R4 odd byte merge", mem[1], 16'h01AB);
  endtask

  task automatic t_word;
    mem[2] = 16'h1234;
    issue(16'h0004, 0, 2'b00, 16'hBEEF, 0, 0);
    chk(mem[2] == 16'hBEEF, "R5 word store", mem[2], 16'hBEEF);
    issue(16'h0005, 0, 2'b00, 16'hC0DE, 0, 0);
    chk(mem[2] == 16'hC0DE, "R5 R1 word store odd addr", mem[2], 16'hC0DE);
  endtask

  task automatic t_clear_set;
    mem[3] = 16'hA5C3;
    issue(16'h0007, 1, 2'b01, 16'h1111, 0, 0);
    chk(mem[3] == 16'hA500, "R6 byte clear odd", mem[3], 16'hA500);
    mem[4] = 16'h1357;
    issue(16'h0008, 0, 2'b10, 16'h0000, 0, 0);
    chk(mem[4] == 16'hFFFF, "R6 word set", mem[4], 16'hFFFF);
    mem[5] = 16'h1200;
    issue(16'h000A, 1, 2'b10, 16'h0000, 0, 0);
    chk(mem[5] == 16'hFF00, "R6 byte set even", mem[5], 16'hFF00);
    mem[8] = 16'h4321;
    issue(16'h0010, 0, 2'b01, 16'hFFFF, 0, 0);
    chk(mem[8] == 16'h0000, "R6 word clear", mem[8], 16'h0000);
  endtask

  task automatic t_busy;
    mem[6] = 16'h3344;
    mem[7] = 16'h5566;
    issue(16'h000D, 1, 2'b00, 16'h0099, 1, 16'h000E);
    chk(mem[6] == 16'h3399, "R8 R4 accepted op", mem[6], 16'h3399);
    chk(mem[7] == 16'h5566, "R8 busy request ignored", mem[7], 16'h5566);
  endtask

  initial begin
    #200000;
    if (!finished) begin
      miscompares++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) mem[i] = '0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    @(negedge clk);
    t_reset;
    t_byte_even;
    t_byte_odd;
    t_word;
    t_clear_set;
    t_busy;
    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end
endmodule